// File: doc/BRIEF.md
# Six-Pin Multi-Mode GPIO Port

This block is a six-pin general-purpose I/O port that sits behind a small byte-wide register port. A host selects a drive style for each of the four lower pins through a configuration register. Through a pin-state register it then sets the value each pin should present. The upper two pins always behave as quasi-bidirectional pins. For every pin the block produces an output value, an output enable and a weak-pullup indication for the pad ring. Pad analog behaviour stays outside the block.

Pin inputs are brought into the clock domain by a two-flop synchronizer. A per-pin glitch filter then accepts a new level only after it has been seen for several consecutive samples. Reading the state register returns these filtered levels, not the stored output values. The register port has no handshake. A write takes effect at the clock edge on which `bus_wr` is high, and read data is a combinational function of `bus_addr`, so the port never applies back-pressure.

Top module: `gpio6_port`

## Requirements
- R1: While and after reset, address 0x00 reads 0x00 and address 0x01 reads 0x3F when all pins are high. Every pin is quasi-bidirectional with a stored 1, so `pin_oe` is 0 and `pin_wpu` is 1 for all six pins.
- R2: Address 0x00 is a read/write configuration register. Pin n (n = 0..3) takes its mode from bits 2n+1:2n, with the upper bit as the high bit of the code. The codes are 00 quasi-bidirectional, 01 input-only, 10 push-pull and 11 open-drain. `pin_out` is 0 whenever `pin_oe` is 0.
- R3: In push-pull mode `pin_oe` is 1, `pin_out` equals the stored state bit and `pin_wpu` is 0.
- R4: In input-only mode `pin_oe`, `pin_out` and `pin_wpu` are all 0, whatever the state bit holds.
- R5: In open-drain mode the pin drives 0 (`pin_oe`=1, `pin_out`=0) when the state bit is 0. It is released (`pin_oe`=0) when the state bit is 1, and `pin_wpu` is 0.
- R6: In quasi-bidirectional mode a stored 0 drives low with `pin_wpu`=0, and a stored 1 asserts `pin_wpu`. A 0-to-1 write of the state bit drives the pin high (`pin_oe`=1, `pin_out`=1) for exactly 2 cycles after the write edge. After that the pin is released.
- R7: Pins 4 and 5 always follow the quasi-bidirectional behaviour of R6, whatever the configuration register holds.
- R8: A write to address 0x01 stores bits 5:0 as the state bits of pins 5..0 and ignores bits 7:6. A read of 0x01 returns the filtered pin levels in bits 5:0 and zeros in bits 7:6.
- R9: A new pin input level shows in the 0x01 read data 5 clock edges after it is applied (2 synchronizer stages plus 3 consecutive equal samples). A level held for fewer than 3 samples never shows.
- R10: Writes to addresses other than 0x00 and 0x01 change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 6 | Raw pin levels from the pads |
| pin_out | output | 6 | Per-pin output value |
| pin_oe | output | 6 | Per-pin output enable |
| pin_wpu | output | 6 | Per-pin weak-pullup indication |

## Verification
Drive outputs change on the write edge itself, so the bench checks them at the falling edge right after a write. For a 0-to-1 quasi-bidirectional write it checks the two following falling edges too, plus the third, where the pin must be released. Filtered levels appear in the read data on the fifth rising edge after an input change. The bench checks the old value after the fourth edge and the new value after the fifth. Glitches of two samples are watched over ten cycles and must never appear. Register readback is combinational and is sampled one delta after the address is set at a falling edge.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
  typedef enum logic [1:0] {
    MODE_QUASI     = 2'b00,
    MODE_INPUT     = 2'b01,
    MODE_PUSHPULL  = 2'b10,
    MODE_OPENDRAIN = 2'b11
  } pin_mode_e;

  localparam int unsigned REG_W = 8;
  localparam logic [7:0] ADDR_CFG   = 8'h00;
  localparam logic [7:0] ADDR_STATE = 8'h01;
endpackage

// File: rtl/gpio6_in_filter.sv
module gpio6_in_filter #(
  parameter int unsigned STABLE_N = 3,
  parameter logic        RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  localparam int unsigned CNT_W = $clog2(STABLE_N + 1);

  logic             sync1, sync2;
  logic [CNT_W-1:0] run_cnt;
  logic             level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= RST_VAL;
      sync2   <= RST_VAL;
      run_cnt <= '0;
      level_q <= RST_VAL;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      if (sync2 == level_q) begin
        run_cnt <= '0;
      end else if (run_cnt == CNT_W'(STABLE_N - 1)) begin
        level_q <= sync2;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/gpio6_pin_drive.sv
module gpio6_pin_drive
  import gpio6_pkg::*;
#(
  parameter int unsigned BOOST_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode_i,
  input  logic      state_i,
  input  logic      rise_i,
  output logic      oe_o,
  output logic      out_o,
  output logic      wpu_o
);
  localparam int unsigned BW = $clog2(BOOST_CYC + 1);

  logic [BW-1:0] boost_cnt;
  logic          boost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boost_cnt <= '0;
    end else if (rise_i) begin
      boost_cnt <= BW'(BOOST_CYC);
    end else if (!state_i) begin
      boost_cnt <= '0;
    end else if (boost_cnt != '0) begin
      boost_cnt <= boost_cnt - 1'b1;
    end
  end

  assign boost = (boost_cnt != '0);

  always_comb begin
    oe_o  = 1'b0;
    out_o = 1'b0;
    wpu_o = 1'b0;
    unique case (mode_i)
      MODE_QUASI: begin
        oe_o  = !state_i || boost;
        out_o = state_i && boost;
        wpu_o = state_i;
      end
      MODE_INPUT: begin
        oe_o = 1'b0;
      end
      MODE_PUSHPULL: begin
        oe_o  = 1'b1;
        out_o = state_i;
      end
      MODE_OPENDRAIN: begin
        oe_o = !state_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
  import gpio6_pkg::*;
#(
  parameter int unsigned N_CFG     = 4,
  parameter int unsigned N_FIX     = 2,
  parameter int unsigned STABLE_N  = 3,
  parameter int unsigned BOOST_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [7:0]               bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  input  logic [N_CFG+N_FIX-1:0]   pin_in,
  output logic [N_CFG+N_FIX-1:0]   pin_out,
  output logic [N_CFG+N_FIX-1:0]   pin_oe,
  output logic [N_CFG+N_FIX-1:0]   pin_wpu
);
  localparam int unsigned N_PIN = N_CFG + N_FIX;
  localparam int unsigned CFG_W = 2 * N_CFG;

  logic [CFG_W-1:0] cfg_q;
  logic [N_PIN-1:0] state_q;
  logic [N_PIN-1:0] state_rise;
  logic [N_PIN-1:0] filt_lvl;
  logic             wr_cfg, wr_state;

  assign wr_cfg   = bus_wr && (bus_addr == ADDR_CFG);
  assign wr_state = bus_wr && (bus_addr == ADDR_STATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      state_q <= '1;
    end else begin
      if (wr_cfg)   cfg_q   <= bus_wdata[CFG_W-1:0];
      if (wr_state) state_q <= bus_wdata[N_PIN-1:0];
    end
  end

  assign state_rise = wr_state ? (bus_wdata[N_PIN-1:0] & ~state_q) : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CFG)        bus_rdata[CFG_W-1:0] = cfg_q;
    else if (bus_addr == ADDR_STATE) bus_rdata[N_PIN-1:0] = filt_lvl;
  end

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    pin_mode_e mode;
    if (i < N_CFG) begin : g_cfg
      assign mode = pin_mode_e'(cfg_q[2*i+1 -: 2]);
    end else begin : g_fix
      assign mode = MODE_QUASI;
    end

    gpio6_pin_drive #(.BOOST_CYC(BOOST_CYC)) u_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode),
      .state_i(state_q[i]),
      .rise_i (state_rise[i]),
      .oe_o   (pin_oe[i]),
      .out_o  (pin_out[i]),
      .wpu_o  (pin_wpu[i])
    );

    gpio6_in_filter #(.STABLE_N(STABLE_N), .RST_VAL(1'b1)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in[i]),
      .level_o(filt_lvl[i])
    );
  end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk #(
  parameter int unsigned N_CFG     = 4,
  parameter int unsigned N_PIN     = 6,
  parameter int unsigned BOOST_CYC = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*N_CFG-1:0] cfg_q,
  input logic [N_PIN-1:0]   state_q,
  input logic [7:0]         bus_addr,
  input logic [7:0]         bus_rdata,
  input logic [N_PIN-1:0]   pin_out,
  input logic [N_PIN-1:0]   pin_oe,
  input logic [N_PIN-1:0]   pin_wpu
);
  for (genvar i = 0; i < N_PIN; i++) begin : g_all
    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[i] |-> !pin_out[i]); // R2
  end

  for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
    logic [1:0] m;
    assign m = cfg_q[2*i+1 -: 2];
    AST_INPUT_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b01) |-> (!pin_oe[i] && !pin_wpu[i])); // R4
    AST_PUSHPULL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b10) |-> (pin_oe[i] && pin_out[i] == state_q[i])); // R3
    AST_OPENDRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b11) |-> (pin_oe[i] == !state_q[i] && !pin_out[i])); // R5
    AST_QUASI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b00 && !state_q[i]) |-> (pin_oe[i] && !pin_out[i] && !pin_wpu[i])); // R6
    if (BOOST_CYC == 2) begin : g_boost
      AST_QUASI_BOOST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'b00 && state_q[i] && $past(state_q[i]) && $past(state_q[i], 2))
          |-> !pin_oe[i]); // R6
    end
  end

  for (genvar i = N_CFG; i < N_PIN; i++) begin : g_fix
    AST_FIXED_QUASI: assert property (@(posedge clk) disable iff (!rst_n)
      state_q[i] ? pin_wpu[i] : (pin_oe[i] && !pin_out[i])); // R7
  end

  AST_STATE_READ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h01) |-> ((bus_rdata >> N_PIN) == 8'h00)); // R8
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > 8'h01) |-> (bus_rdata == 8'h00)); // R10
endmodule

bind gpio6_port gpio6_port_chk #(
  .N_CFG(N_CFG), .N_PIN(N_CFG + N_FIX), .BOOST_CYC(BOOST_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_q    (cfg_q),
  .state_q  (state_q),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .pin_wpu  (pin_wpu)
);

// File: tb/gpio6_port_bench.sv
module gpio6_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [5:0] pin_in = 6'h3F;
  logic [5:0] pin_out, pin_oe, pin_wpu;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] exp_cfg;
  logic [5:0] exp_state;
  int         bcnt [6];

  always #10 clk = ~clk;

  gpio6_port u_gpio6_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_wpu(pin_wpu)
  );

  // reference model of the register and boost timing, built from R2..R8, R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_cfg   = 8'h00;
      exp_state = 6'h3F;
      for (int i = 0; i < 6; i++) bcnt[i] = 0;
    end else begin
      logic [5:0] nxt;
      nxt = (bus_wr && bus_addr == 8'h01) ? bus_wdata[5:0] : exp_state;
      for (int i = 0; i < 6; i++) begin
        if (nxt[i] && !exp_state[i]) bcnt[i] = 2;
        else if (!nxt[i]) bcnt[i] = 0;
        else if (bcnt[i] > 0) bcnt[i] = bcnt[i] - 1;
      end
      exp_state = nxt;
      if (bus_wr && bus_addr == 8'h00) exp_cfg = bus_wdata;
    end
  end

  function automatic logic [1:0] pin_mode(int i);
    return (i < 4) ? exp_cfg[2*i+1 -: 2] : 2'b00;
  endfunction

  // returns {oe, out, wpu}
  function automatic logic [2:0] exp_drive(logic [1:0] m, logic st, int bc);
    case (m)
      2'b00: return {(!st || bc > 0), (st && bc > 0), st};
      2'b01: return 3'b000;
      2'b10: return {1'b1, st, 1'b0};
      default: return {!st, 1'b0, 1'b0};
    endcase
  endfunction

  function automatic string pin_tag(int i, logic [1:0] m);
    if (i >= 4) return "R7";
    case (m)
      2'b00: return "R6";
      2'b01: return "R4";
      2'b10: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_pins();
    for (int i = 0; i < 6; i++) begin
      logic [2:0] e;
      e = exp_drive(pin_mode(i), exp_state[i], bcnt[i]);
      check(pin_tag(i, pin_mode(i)), {5'b0, pin_oe[i], pin_out[i], pin_wpu[i]}, {5'b0, e});
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd4242));

    // R1: reset state
    repeat (3) @(negedge clk);
    bus_read(8'h00, rd); check("R1 cfg", rd, 8'h00);
    bus_read(8'h01, rd); check("R1 state", rd, 8'h3F);
    check("R1 oe", {2'b0, pin_oe}, 8'h00);
    check("R1 wpu", {2'b0, pin_wpu}, 8'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe after", {2'b0, pin_oe}, 8'h00);

    // R2: config readback and field mapping
    bus_write(8'h00, 8'hE4);
    bus_read(8'h00, rd); check("R2 cfg readback", rd, 8'hE4);
    check_pins();

    // R6: quasi boost timing on pin 0..5, all quasi
    bus_write(8'h00, 8'h00);
    bus_write(8'h01, 8'h00);
    check_pins();
    bus_write(8'h01, 8'h3F);
    check("R6 boost c1", {2'b0, pin_oe & pin_out}, 8'h3F);
    @(negedge clk);
    check("R6 boost c2", {2'b0, pin_oe & pin_out}, 8'h3F);
    @(negedge clk);
    check("R6 released", {2'b0, pin_oe}, 8'h00);
    check("R6 wpu", {2'b0, pin_wpu}, 8'h3F);

    // R7: fixed pins ignore config
    bus_write(8'h00, 8'hAA);
    bus_write(8'h01, 8'h0F);
    check("R7 fixed low", {6'b0, pin_oe[5:4] & ~pin_out[5:4]}, 8'h03);
    check_pins();

    // R8: bits 7:6 of state write ignored
    bus_write(8'h01, 8'hC0);
    check_pins();
    bus_read(8'h01, rd); check("R8 read pad", rd, 8'h3F);

    // R10: unmapped write and read
    bus_write(8'h05, 8'hFF);
    bus_read(8'h00, rd); check("R10 cfg kept", rd, 8'hAA);
    check_pins();
    bus_read(8'h07, rd); check("R10 read zero", rd, 8'h00);

    // R9: filter latency, 4 edges old, 5th edge new
    bus_addr = 8'h01;
    @(negedge clk); pin_in = 6'h2A;
    repeat (4) @(negedge clk);
    #1 check("R9 before", bus_rdata, 8'h3F);
    @(negedge clk);
    #1 check("R9 after", bus_rdata, 8'h2A);

    // R9: two-sample glitch rejected
    @(negedge clk); pin_in = 6'h15;
    repeat (2) @(negedge clk);
    pin_in = 6'h2A;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      #1 check("R9 glitch", bus_rdata, 8'h2A);
    end
    // R9: three-sample pulse accepted
    @(negedge clk); pin_in = 6'h15;
    repeat (3) @(negedge clk);
    pin_in = 6'h2A;
    begin
      logic seen = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        #1 if (bus_rdata == 8'h15) seen = 1'b1;
      end
      check("R9 pulse3 seen", {7'b0, seen}, 8'h01);
    end

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [5:0] pv;
      bus_write(8'h00, 8'($urandom));
      check_pins();
      bus_write(8'h01, 8'($urandom));
      for (int c = 0; c < 3; c++) begin
        check_pins();
        @(negedge clk);
      end
      pv = 6'($urandom);
      pin_in = pv;
      repeat (7) @(negedge clk);
      bus_read(8'h01, rd); check("R9 random level", rd, {2'b0, pv});
    end

    finish_run();
  end
endmodule